// File: doc/BRIEF.md
# DMA Interrupt and Control Register Block

This block is the register front end of a DMA controller. It gathers interrupt requests from eight transmit channels, eight receive channels and a host-error source. Each of the three source groups has a raw view, a masked view, and a pair of mask registers: one where writing ones enables sources and one where writing ones disables them. The OR of all masked status drives one interrupt line. That line is paced by a small arm/fire state machine and re-armed by a write to an end-of-interrupt address.

The same 32-bit register port also holds several other registers: a transmit enable and a receive enable, a soft reset that clears itself, a control register with four mode bits and one write-only idle command, a packed status word built from engine inputs, and a 16-bit receive buffer offset. The host writes a register with `reg_wr` high for one cycle, and the write takes effect at that clock edge. Read data follows `reg_addr` combinationally.

Two state machines are named. The interrupt machine (`irq_state_e`) has the states IRQ_ARMED and IRQ_FIRED. Its transitions are:
- ARMED to FIRED on any masked pending bit while no end-of-interrupt write is present.
- FIRED to ARMED on an end-of-interrupt write.

The soft-reset machine (`srst_state_e`) has the states SR_IDLE and SR_BUSY. Its transitions are:
- IDLE to BUSY on a write with bit 0 set to the reset register.
- BUSY to IDLE once its down-counter reaches zero.

Top module: `dmairq_regs`

## Requirements
- R1: After reset every register reads 0, `irq` is low and both enables are low. Any address not listed in these requirements reads 0.
- R2: The three raw status views are at 0x80 (transmit), 0xA0 (receive) and 0xB0 (DMA). Each reads the current source levels. In the DMA group only bit 1 is implemented, and it carries `host_err`.
- R3: A write to a mask-set register (0x88, 0xA8, 0xB8) sets each mask bit where the data has a 1 and leaves the rest unchanged. Mask bits for unimplemented sources stay 0. The mask reads back at both its set and its clear address.
- R4: A write to a mask-clear register (0x8C, 0xAC, 0xBC) clears each mask bit where the data has a 1. Writing all ones clears the whole group.
- R5: The masked status views (0x84, 0xA4, 0xB4) read raw AND mask.
- R6: In IRQ_ARMED, any masked pending bit moves the machine to IRQ_FIRED at the next edge, and `irq` is high in IRQ_FIRED. Once fired, `irq` stays high until an end-of-interrupt write, even if the sources go away.
- R7: A write to 0x94 (end of interrupt) returns the machine to IRQ_ARMED, so `irq` is low in the next cycle. If masked status is still pending, `irq` rises again one cycle later; otherwise it stays low.
- R8: Bit 0 of 0x04 is the transmit enable and bit 0 of 0x14 is the receive enable. Both read back.
- R9: Writing 1 in bit 0 of 0x1C starts a soft reset. Address 0x1C reads 1 for exactly 16 cycles after the write edge and 0 afterwards. Writing 0 there has no effect.
- R10: While the soft reset runs, all mask registers and both enables are forced to 0, and writes to them are ignored.
- R11: The control register at 0x20 stores bit 0 (fixed transmit priority), bit 1 (receive ownership flip), bit 2 (receive offset/length update) and bit 4 (copy error frames). Writing 1 in bit 3 gives a one-cycle `idle_cmd` pulse in the cycle after the write, and bit 3 always reads 0.
- R12: The status word at 0x24 packs the engine inputs as follows: `eng_idle` in bit 31, transmit error code in bits 23:20, transmit error channel in bits 18:16, receive error code in bits 15:12, receive error channel in bits 10:8. All other bits read 0.
- R13: The receive buffer offset at 0x28 stores the low 16 bits of the write data. Bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tx_src | input | 8 | Transmit channel interrupt levels |
| rx_src | input | 8 | Receive channel interrupt levels |
| host_err | input | 1 | Host-error interrupt level |
| eng_idle | input | 1 | Engine idle flag |
| tx_err_code | input | 4 | Transmit error code |
| tx_err_chan | input | 3 | Transmit error channel |
| rx_err_code | input | 4 | Receive error code |
| rx_err_chan | input | 3 | Receive error channel |
| irq | output | 1 | Combined interrupt |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| soft_rst_busy | output | 1 | Soft reset in progress |
| prio_fixed | output | 1 | Fixed transmit priority mode |
| own_flip | output | 1 | Receive ownership flip mode |
| offlen_upd | output | 1 | Receive offset/length update mode |
| copy_err_frames | output | 1 | Copy error frames mode |
| idle_cmd | output | 1 | One-cycle idle command pulse |
| rx_buf_ofs | output | 16 | Receive buffer offset |

## Verification
Some rules are checked by the assertions on every cycle:
- a set or clear write lands in the mask on the next edge;
- the mask and both enables are zero for as long as the soft reset is busy;
- the soft reset leaves BUSY exactly when its counter expires;
- a fired interrupt holds until an end-of-interrupt write, which always drops it.

Other rules can only be shown by the bench's scenarios: the address map, the packing of the status and control fields, the exact 16-cycle reset window as seen over the bus, and re-firing after an end-of-interrupt while a source is still pending. The bench drives random source and mask patterns against a mask model of its own and adds directed cases for these corners.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam logic [7:0] A_TXCTL = 8'h04;
    localparam logic [7:0] A_RXCTL = 8'h14;
    localparam logic [7:0] A_SRST  = 8'h1C;
    localparam logic [7:0] A_CTRL  = 8'h20;
    localparam logic [7:0] A_STAT  = 8'h24;
    localparam logic [7:0] A_RXOFS = 8'h28;
    localparam logic [7:0] A_EOI   = 8'h94;

    localparam int NUM_GRP = 3;
    localparam int GRP_TX  = 0;
    localparam int GRP_RX  = 1;
    localparam int GRP_DMA = 2;
    localparam logic [7:0] GRP_BASE [NUM_GRP] = '{8'h80, 8'hA0, 8'hB0};

    localparam logic [7:0] OFS_RAW    = 8'h00;
    localparam logic [7:0] OFS_MASKED = 8'h04;
    localparam logic [7:0] OFS_SET    = 8'h08;
    localparam logic [7:0] OFS_CLR    = 8'h0C;

    localparam int HOST_ERR_BIT = 1;

    typedef enum logic {IRQ_ARMED, IRQ_FIRED} irq_state_e;
    typedef enum logic {SR_IDLE, SR_BUSY} srst_state_e;
endpackage

// File: rtl/dmairq_mask_grp.sv
module dmairq_mask_grp #(
    parameter int W = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_all,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] src,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask <= '0;
        else if (clear_all) mask <= '0;
        else if (wr_set)    mask <= mask | (wval & IMPL);
        else if (wr_clr)    mask <= mask & ~wval;
    end

    assign raw    = src & IMPL;
    assign masked = raw & mask;

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set && !clear_all |=> ((mask & $past(wval & IMPL)) == $past(wval & IMPL)));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && !clear_all |=> ((mask & $past(wval)) == '0));
    // R3
    mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & ~IMPL) == '0);
endmodule

// File: rtl/dmairq_irq_fsm.sv
module dmairq_irq_fsm
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_ARMED: if (!eoi && pending) state_d = IRQ_FIRED;
            IRQ_FIRED: if (eoi)             state_d = IRQ_ARMED;
            default:                        state_d = IRQ_ARMED;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_FIRED);
    end

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !eoi |=> irq);
    // R7
    irq_eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq);
    // R6
    irq_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !pending |=> !irq);
endmodule

// File: rtl/dmairq_srst_fsm.sv
module dmairq_srst_fsm
    import dmairq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(RST_CYCLES - 1);

    srst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (start)         state_d = SR_BUSY;
            SR_BUSY: if (cnt_q == '0)   state_d = SR_IDLE;
            default:                    state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (state_q == SR_IDLE && start)     cnt_q <= CNT_INIT;
        else if (state_q == SR_BUSY && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        busy = (state_q == SR_BUSY);
    end

    // R9
    srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && cnt_q == CNT_INIT);
    // R9
    srst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt_q == '0 |=> !busy);
    // R9
    srst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt_q != '0 |=> busy);
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
    import dmairq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int RST_CYCLES = 16,
    parameter int OFS_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] tx_src,
    input  logic [NUM_CH-1:0] rx_src,
    input  logic              host_err,
    input  logic              eng_idle,
    input  logic [3:0]        tx_err_code,
    input  logic [2:0]        tx_err_chan,
    input  logic [3:0]        rx_err_code,
    input  logic [2:0]        rx_err_chan,
    output logic              irq,
    output logic              tx_en,
    output logic              rx_en,
    output logic              soft_rst_busy,
    output logic              prio_fixed,
    output logic              own_flip,
    output logic              offlen_upd,
    output logic              copy_err_frames,
    output logic              idle_cmd,
    output logic [OFS_W-1:0]  rx_buf_ofs
);
    localparam logic [NUM_CH-1:0] DMA_IMPL = NUM_CH'(1) << HOST_ERR_BIT;
    localparam logic [4:0] CTRL_STORE = 5'b10111;

    logic [NUM_CH-1:0] grp_src    [NUM_GRP];
    logic [NUM_CH-1:0] grp_raw    [NUM_GRP];
    logic [NUM_CH-1:0] grp_mask   [NUM_GRP];
    logic [NUM_CH-1:0] grp_masked [NUM_GRP];
    logic [NUM_GRP-1:0] grp_pend;
    logic [4:0] ctrl_q;
    logic tx_en_q, rx_en_q, idle_cmd_q;
    logic [OFS_W-1:0] ofs_q;
    logic busy, eoi_wr, srst_wr;
    logic wdata_unused;

    assign wdata_unused = ^reg_wdata[31:16];

    assign grp_src[GRP_TX]  = tx_src;
    assign grp_src[GRP_RX]  = rx_src;
    assign grp_src[GRP_DMA] = host_err ? DMA_IMPL : '0;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [NUM_CH-1:0] IMPL_G = (g == GRP_DMA) ? DMA_IMPL : '1;
        dmairq_mask_grp #(.W(NUM_CH), .IMPL(IMPL_G)) grp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_all (busy),
            .wr_set    (reg_wr && reg_addr == GRP_BASE[g] + OFS_SET),
            .wr_clr    (reg_wr && reg_addr == GRP_BASE[g] + OFS_CLR),
            .wval      (reg_wdata[NUM_CH-1:0]),
            .src       (grp_src[g]),
            .raw       (grp_raw[g]),
            .mask      (grp_mask[g]),
            .masked    (grp_masked[g])
        );
        assign grp_pend[g] = |grp_masked[g];
    end

    assign eoi_wr  = reg_wr && reg_addr == A_EOI;
    assign srst_wr = reg_wr && reg_addr == A_SRST && reg_wdata[0];

    dmairq_irq_fsm irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|grp_pend),
        .eoi     (eoi_wr),
        .irq     (irq)
    );

    dmairq_srst_fsm #(.RST_CYCLES(RST_CYCLES)) srst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_wr),
        .busy  (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else if (busy) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_TXCTL) tx_en_q <= reg_wdata[0];
            if (reg_addr == A_RXCTL) rx_en_q <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ofs_q      <= '0;
            idle_cmd_q <= 1'b0;
        end else begin
            idle_cmd_q <= reg_wr && reg_addr == A_CTRL && reg_wdata[3];
            if (reg_wr && reg_addr == A_CTRL)  ctrl_q <= reg_wdata[4:0] & CTRL_STORE;
            if (reg_wr && reg_addr == A_RXOFS) ofs_q  <= reg_wdata[OFS_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_TXCTL: reg_rdata = {31'd0, tx_en_q};
            A_RXCTL: reg_rdata = {31'd0, rx_en_q};
            A_SRST:  reg_rdata = {31'd0, busy};
            A_CTRL:  reg_rdata = {27'd0, ctrl_q};
            A_STAT:  reg_rdata = {eng_idle, 7'd0, tx_err_code, 1'b0, tx_err_chan,
                                  rx_err_code, 1'b0, rx_err_chan, 8'd0};
            A_RXOFS: reg_rdata = 32'(ofs_q);
            default: reg_rdata = '0;
        endcase
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == GRP_BASE[g] + OFS_RAW)    reg_rdata = 32'(grp_raw[g]);
            if (reg_addr == GRP_BASE[g] + OFS_MASKED) reg_rdata = 32'(grp_masked[g]);
            if (reg_addr == GRP_BASE[g] + OFS_SET)    reg_rdata = 32'(grp_mask[g]);
            if (reg_addr == GRP_BASE[g] + OFS_CLR)    reg_rdata = 32'(grp_mask[g]);
        end
    end

    assign tx_en           = tx_en_q;
    assign rx_en           = rx_en_q;
    assign soft_rst_busy   = busy;
    assign prio_fixed      = ctrl_q[0];
    assign own_flip        = ctrl_q[1];
    assign offlen_upd      = ctrl_q[2];
    assign copy_err_frames = ctrl_q[4];
    assign idle_cmd        = idle_cmd_q;
    assign rx_buf_ofs      = ofs_q;

    // R10
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !tx_en_q && !rx_en_q && grp_mask[GRP_TX] == '0 &&
                 grp_mask[GRP_RX] == '0 && grp_mask[GRP_DMA] == '0);
    // R11
    idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd_q |=> !idle_cmd_q || $past(reg_wr && reg_addr == A_CTRL && reg_wdata[3]));
endmodule

// File: tb/dmairq_regs_tb_top.sv
module dmairq_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] tx_src = '0, rx_src = '0;
    logic host_err = 1'b0, eng_idle = 1'b0;
    logic [3:0] tx_err_code = '0, rx_err_code = '0;
    logic [2:0] tx_err_chan = '0, rx_err_chan = '0;
    logic irq, tx_en, rx_en, soft_rst_busy, prio_fixed, own_flip, offlen_upd;
    logic copy_err_frames, idle_cmd;
    logic [15:0] rx_buf_ofs;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rd;
    logic [NCH-1:0] mdl [3];
    logic [7:0] base [3] = '{8'h80, 8'hA0, 8'hB0};
    logic [NCH-1:0] impl [3] = '{8'hFF, 8'hFF, 8'h02};

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_src(tx_src),
        .rx_src(rx_src), .host_err(host_err), .eng_idle(eng_idle),
        .tx_err_code(tx_err_code), .tx_err_chan(tx_err_chan),
        .rx_err_code(rx_err_code), .rx_err_chan(rx_err_chan), .irq(irq),
        .tx_en(tx_en), .rx_en(rx_en), .soft_rst_busy(soft_rst_busy),
        .prio_fixed(prio_fixed), .own_flip(own_flip), .offlen_upd(offlen_upd),
        .copy_err_frames(copy_err_frames), .idle_cmd(idle_cmd),
        .rx_buf_ofs(rx_buf_ofs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] exp_raw(input int g);
        if (g == 0) return tx_src;
        if (g == 1) return rx_src;
        return host_err ? 8'h02 : 8'h00;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd13));
        for (int g = 0; g < 3; g++) mdl[g] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rdreg(8'h88, rd); chk("R1 tx mask reset", rd, 0);
        rdreg(8'h04, rd); chk("R1 tx ctl reset", rd, 0);
        rdreg(8'h20, rd); chk("R1 ctrl reset", rd, 0);
        chk("R1 irq reset", {31'd0, irq}, 0);
        rdreg(8'h40, rd); chk("R1 unmapped read", rd, 0);
        rdreg(8'h94, rd); chk("R1 eoi read", rd, 0);

        // R2 R3 R4 R5 random mask/source patterns
        for (int it = 0; it < 40; it++) begin
            int g;
            logic [31:0] sv, cv;
            g = $urandom % 3;
            sv = $urandom;
            cv = (it == 39) ? 32'hFFFF_FFFF : $urandom;
            wr(base[g] + 8'h08, sv);
            mdl[g] = mdl[g] | (sv[NCH-1:0] & impl[g]);
            rdreg(base[g] + 8'h08, rd); chk("R3 mask after set", rd, 32'(mdl[g]));
            wr(base[g] + 8'h0C, cv);
            mdl[g] = mdl[g] & ~cv[NCH-1:0];
            rdreg(base[g] + 8'h0C, rd); chk("R4 mask after clear", rd, 32'(mdl[g]));
            tx_src = NCH'($urandom); rx_src = NCH'($urandom); host_err = 1'($urandom);
            rdreg(base[g], rd); chk("R2 raw view", rd, 32'(exp_raw(g)));
            rdreg(base[g] + 8'h04, rd); chk("R5 masked view", rd, 32'(exp_raw(g) & mdl[g]));
            if (it % 4 == 0) begin
                wr(8'hB8, 32'hFF); mdl[2] = 8'h02;
                rdreg(8'hB8, rd); chk("R3 dma impl bits", rd, 32'h2);
            end
        end

        // R6 R7 interrupt sequencing
        for (int g = 0; g < 3; g++) begin wr(base[g] + 8'h0C, 32'hFFFF_FFFF); mdl[g] = '0; end
        wr(8'h94, 0);
        tx_src = 8'h10; rx_src = 0; host_err = 0;
        idle(2);
        chk("R6 no irq while masked", {31'd0, irq}, 0);
        wr(8'h88, 32'h10);
        chk("R6 irq not yet", {31'd0, irq}, 0);
        idle(1);
        chk("R6 irq fires", {31'd0, irq}, 1);
        tx_src = 0;
        idle(3);
        chk("R6 irq held after source drop", {31'd0, irq}, 1);
        tx_src = 8'h10;
        wr(8'h94, 0);
        chk("R7 irq low after eoi", {31'd0, irq}, 0);
        idle(1);
        chk("R7 irq refires while pending", {31'd0, irq}, 1);
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'h94, 0);
        idle(2);
        chk("R7 irq stays low when nothing pending", {31'd0, irq}, 0);
        host_err = 1;
        wr(8'hB8, 32'h2);
        idle(1);
        chk("R6 host error fires", {31'd0, irq}, 1);
        wr(8'hBC, 32'h2); wr(8'h94, 0); host_err = 0;

        // R8 enables
        wr(8'h04, 32'h1); wr(8'h14, 32'h1);
        rdreg(8'h04, rd); chk("R8 tx enable read", rd, 1);
        rdreg(8'h14, rd); chk("R8 rx enable read", rd, 1);
        chk("R8 enable pins", {30'd0, tx_en, rx_en}, 3);
        wr(8'h14, 32'h0);
        chk("R8 rx disabled", {31'd0, rx_en}, 0);
        wr(8'h14, 32'h1);

        // R9 R10 soft reset
        wr(8'h1C, 32'h0);
        rdreg(8'h1C, rd); chk("R9 zero write no effect", rd, 0);
        wr(8'hA8, 32'h5A);
        wr(8'h1C, 32'h1);
        rdreg(8'h1C, rd); chk("R9 busy after start", rd, 1);
        idle(1);
        rdreg(8'hA8, rd); chk("R10 mask cleared", rd, 0);
        chk("R10 enables cleared", {30'd0, tx_en, rx_en}, 0);
        wr(8'hA8, 32'h33);
        rdreg(8'hA8, rd); chk("R10 mask write ignored while busy", rd, 0);
        wr(8'h04, 32'h1);
        chk("R10 enable write ignored while busy", {31'd0, tx_en}, 0);
        idle(10);
        rdreg(8'h1C, rd); chk("R9 busy at cycle 16", rd, 1);
        idle(1);
        rdreg(8'h1C, rd); chk("R9 done after 16 cycles", rd, 0);
        wr(8'hA8, 32'h33);
        rdreg(8'hA8, rd); chk("R10 mask writable after reset", rd, 32'h33);
        wr(8'hAC, 32'hFF);

        // R11 control register
        wr(8'h20, 32'h1F);
        chk("R11 idle pulse", {31'd0, idle_cmd}, 1);
        rdreg(8'h20, rd); chk("R11 ctrl read bit3 zero", rd, 32'h17);
        chk("R11 ctrl pins", {28'd0, copy_err_frames, offlen_upd, own_flip, prio_fixed}, 4'hF);
        idle(1);
        chk("R11 idle pulse one cycle", {31'd0, idle_cmd}, 0);
        wr(8'h20, 32'h2);
        rdreg(8'h20, rd); chk("R11 ctrl rewrite", rd, 32'h2);
        chk("R11 no pulse without bit3", {31'd0, idle_cmd}, 0);

        // R12 status packing
        eng_idle = 1; tx_err_code = 4'hA; tx_err_chan = 3'h5; rx_err_code = 4'h3; rx_err_chan = 3'h6;
        rdreg(8'h24, rd); chk("R12 status pack", rd, 32'h80A5_3600);
        eng_idle = 0; tx_err_code = 4'hF; tx_err_chan = 3'h7; rx_err_code = 4'hF; rx_err_chan = 3'h7;
        rdreg(8'h24, rd); chk("R12 status pack ones", rd, 32'h00F7_F700);

        // R13 offset register
        wr(8'h28, 32'hABCD_1234);
        rdreg(8'h28, rd); chk("R13 offset read", rd, 32'h0000_1234);
        chk("R13 offset pin", 32'(rx_buf_ofs), 32'h1234);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule